// File: doc/BRIEF.md
# Power Control and Reset-Origin Register

This block is an 8-bit special-function register that sits beside a small microcontroller core. It holds the requests for idle and power-down. It also holds two free flags for software, the two serial-port mode selects, and a sticky flag that records whether the last reset came from a supply power-up (a cold start) or from a warm reset. The core reads and writes the register as a whole byte at one fixed address. The mode bits are driven out as registered enables to the clock gating and to the serial port.

A power-on reset sets the cold-start flag and clears every other bit. A warm reset clears the working bits but leaves the cold-start flag as it was. Software can therefore clear the flag after power-up and later read it to tell the two kinds of reset apart. Hardware clears the idle request when an interrupt arrives, and it clears both the idle and power-down requests on any reset.

Top module: `pwr_ctl_reg`

## Requirements
- R1: On a power-on reset the register reads 0x10 when bit 5 is masked: only the cold-start flag is set, and all four mode outputs are 0.
- R2: The register responds only at address 0x87. A write at any other address changes nothing, and a read at any other address returns 0x00.
- R3: Bit positions: bit 7 is double baud, bit 6 is framing-error select, bit 5 is reserved, bit 4 is the cold-start flag, bits 3 and 2 are software flags, bit 1 is power-down and bit 0 is idle.
- R4: The cold-start flag is set only by a power-on reset. A warm reset keeps its current value, whether that value is 0 or 1.
- R5: A software write can set the cold-start flag or clear it.
- R6: Software sets power-down (bit 1). Any reset clears it, and an interrupt request leaves it unchanged.
- R7: Software sets idle (bit 0). An interrupt request or any reset clears it.
- R8: When a write that sets idle falls in the same cycle as an interrupt request, idle ends up 0.
- R9: Bits 3 and 2 are plain software read/write flags.
- R10: A warm reset clears bits 7, 6, 3, 2, 1 and 0.
- R11: The outputs `dbl_baud_o`, `fe_sel_o`, `pdown_en_o` and `idle_en_o` mirror bits 7, 6, 1 and 0. They change at the same clock edge that updates the bit.
- R12: Read data is registered. The edge that samples an address drives out the register contents held before that edge. Bit 5 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on reset, active high |
| wrst_i | input | 1 | Synchronous warm reset, active high |
| sfr_addr_i | input | 8 | Register bus address |
| sfr_we_i | input | 1 | Write strobe |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Registered read data |
| irq_i | input | 1 | Interrupt request, clears idle |
| idle_en_o | output | 1 | Idle request |
| pdown_en_o | output | 1 | Power-down request |
| dbl_baud_o | output | 1 | Serial double baud rate select |
| fe_sel_o | output | 1 | Serial framing-error view select |

## Verification
Writes, resets and interrupt requests all take effect at the edge that samples them, and the mode outputs show the new value right after that edge. A read returns its data one edge after the address is presented. The bench's driver applies every stimulus on the falling edge and queues the expected byte and pin values for each read. The monitor compares them shortly after the rising edge that answers the read. No write, reset or interrupt is applied during a read cycle, so the register state is the same before and after that edge, and the pins and the read data can be checked together.

// File: rtl/pcon_pkg.sv
package pcon_pkg;
  localparam int REG_W = 8;

  // bit positions (neighbours decode these)
  localparam int BIT_DBL  = 7;
  localparam int BIT_FE   = 6;
  localparam int BIT_RSVD = 5;
  localparam int BIT_COLD = 4;
  localparam int BIT_UF1  = 3;
  localparam int BIT_UF0  = 2;
  localparam int BIT_PDN  = 1;
  localparam int BIT_IDL  = 0;

  typedef enum logic [2:0] {
    K_PLAIN,
    K_COLD,
    K_IDLE,
    K_PDOWN,
    K_RSVD
  } bit_kind_e;

  function automatic bit_kind_e bit_kind(input int idx);
    case (idx)
      BIT_RSVD: return K_RSVD;
      BIT_COLD: return K_COLD;
      BIT_IDL:  return K_IDLE;
      BIT_PDN:  return K_PDOWN;
      default:  return K_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/pcon_addr_match.sv
module pcon_addr_match #(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  MATCH  = 8'h87
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              wr_hit_o
);
  localparam logic [ADDR_W-1:0] MATCH_W = ADDR_W'(MATCH);

  always_comb begin
    hit_o    = (addr_i == MATCH_W);
    wr_hit_o = hit_o && we_i;
  end
endmodule

// File: rtl/pcon_bits.sv
module pcon_bits
  import pcon_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              wrst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              irq_i,
  output logic [DATA_W-1:0] q_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam bit_kind_e KIND = bit_kind(i);
    if (KIND == K_RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = wdata_i[i];
      assign q_o[i]      = 1'b0;
    end else begin : g_ff
      logic q_r;
      always_ff @(posedge clk) begin
        if (por_i) begin
          q_r <= (KIND == K_COLD);
        end else if (wrst_i) begin
          if (KIND != K_COLD) q_r <= 1'b0;
        end else if (KIND == K_IDLE && irq_i) begin
          q_r <= 1'b0;
        end else if (wr_en_i) begin
          q_r <= wdata_i[i];
        end
      end
      assign q_o[i] = q_r;
    end
  end

  // R4: a warm reset keeps the cold-start flag
  assert_cold_kept_R4: assert property (@(posedge clk) disable iff (por_i)
    wrst_i |=> (q_o[BIT_COLD] == $past(q_o[BIT_COLD])));

  // R7: an interrupt clears idle
  assert_irq_clears_idle_R7: assert property (@(posedge clk) disable iff (por_i)
    irq_i |=> !q_o[BIT_IDL]);

  // R10: a warm reset clears the working bits
  assert_warm_clears_R10: assert property (@(posedge clk) disable iff (por_i)
    wrst_i |=> (q_o[BIT_DBL] == 1'b0 && q_o[BIT_FE] == 1'b0 &&
                q_o[BIT_UF1] == 1'b0 && q_o[BIT_UF0] == 1'b0 &&
                q_o[BIT_PDN] == 1'b0));
endmodule

// File: rtl/pcon_rd_port.sv
module pcon_rd_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk) begin
    if (por_i)      rdata_o <= '0;
    else if (hit_i) rdata_o <= reg_i;
    else            rdata_o <= '0;
  end

  // R2: reads away from the register address return zero
  assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (por_i)
    !hit_i |=> (rdata_o == '0));
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pcon_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              wrst_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_we_i,
  input  logic [REG_W-1:0]  sfr_wdata_i,
  output logic [REG_W-1:0]  sfr_rdata_o,
  input  logic              irq_i,
  output logic              idle_en_o,
  output logic              pdown_en_o,
  output logic              dbl_baud_o,
  output logic              fe_sel_o
);
  logic             hit;
  logic             wr_hit;
  logic [REG_W-1:0] reg_q;

  pcon_addr_match #(.ADDR_W(ADDR_W), .MATCH(REG_ADDR)) u_match (
    .addr_i   (sfr_addr_i),
    .we_i     (sfr_we_i),
    .hit_o    (hit),
    .wr_hit_o (wr_hit)
  );

  pcon_bits #(.DATA_W(REG_W)) u_bits (
    .clk     (clk),
    .por_i   (por_i),
    .wrst_i  (wrst_i),
    .wr_en_i (wr_hit),
    .wdata_i (sfr_wdata_i),
    .irq_i   (irq_i),
    .q_o     (reg_q)
  );

  pcon_rd_port #(.DATA_W(REG_W)) u_rd (
    .clk     (clk),
    .por_i   (por_i),
    .hit_i   (hit),
    .reg_i   (reg_q),
    .rdata_o (sfr_rdata_o)
  );

  assign idle_en_o  = reg_q[BIT_IDL];
  assign pdown_en_o = reg_q[BIT_PDN];
  assign dbl_baud_o = reg_q[BIT_DBL];
  assign fe_sel_o   = reg_q[BIT_FE];

  // R1: a power-on reset leaves only the cold-start flag set
  assert_por_state_R1: assert property (@(posedge clk) disable iff (wrst_i)
    por_i |=> (sfr_rdata_o == 8'h00 && !idle_en_o && !pdown_en_o &&
               !dbl_baud_o && !fe_sel_o));

  // R6: an interrupt does not clear power-down
  assert_irq_keeps_pd_R6: assert property (@(posedge clk) disable iff (por_i || wrst_i)
    (irq_i && !wr_hit && pdown_en_o) |=> pdown_en_o);

  // R8: interrupt beats a simultaneous idle write
  assert_irq_beats_write_R8: assert property (@(posedge clk) disable iff (por_i)
    (wr_hit && sfr_wdata_i[BIT_IDL] && irq_i) |=> !idle_en_o);

  // R11: mode pins hold without a write or reset
  assert_pins_hold_R11: assert property (@(posedge clk) disable iff (por_i || wrst_i)
    !wr_hit |=> ($stable(dbl_baud_o) && $stable(fe_sel_o)));
endmodule

// File: tb/sim_pwr_ctl_reg.sv
`timescale 1ns/1ps
module sim_pwr_ctl_reg;
  typedef struct {
    logic [7:0] data;
    logic [3:0] pins; // {dbl, fe, pd, idle}
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       wrst_i = 1'b0;
  logic [7:0] sfr_addr_i = 8'h00;
  logic       sfr_we_i = 1'b0;
  logic [7:0] sfr_wdata_i = 8'h00;
  logic [7:0] sfr_rdata_o;
  logic       irq_i = 1'b0;
  logic       idle_en_o, pdown_en_o, dbl_baud_o, fe_sel_o;

  int   n_checks = 0;
  int   n_fail = 0;
  logic rd_valid = 1'b0;
  logic done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  pwr_ctl_reg u0 (
    .clk(clk), .por_i(por_i), .wrst_i(wrst_i),
    .sfr_addr_i(sfr_addr_i), .sfr_we_i(sfr_we_i),
    .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o),
    .irq_i(irq_i), .idle_en_o(idle_en_o), .pdown_en_o(pdown_en_o),
    .dbl_baud_o(dbl_baud_o), .fe_sel_o(fe_sel_o)
  );

  // monitor: pops one expected item per read cycle
  always @(posedge clk) begin
    if (rd_valid) begin
      #1;
      if (q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard empty: got %h, expected a queued item", sfr_rdata_o);
      end else begin
        exp_t e;
        logic [3:0] pins;
        e = q.pop_front();
        pins = {dbl_baud_o, fe_sel_o, pdown_en_o, idle_en_o};
        n_checks++;
        if ((sfr_rdata_o & 8'hDF) !== (e.data & 8'hDF) || pins !== e.pins) begin
          n_fail++;
          $display("FAIL %s: data %h pins %b, expected data %h pins %b",
                   e.tag, sfr_rdata_o & 8'hDF, pins, e.data & 8'hDF, e.pins);
        end
      end
    end
  end

  task automatic idle_cyc();
    @(negedge clk);
    por_i = 0; wrst_i = 0; sfr_we_i = 0; irq_i = 0; rd_valid = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic irq);
    @(negedge clk);
    rd_valid = 0; por_i = 0; wrst_i = 0;
    sfr_addr_i = a; sfr_we_i = 1; sfr_wdata_i = d; irq_i = irq;
    idle_cyc();
  endtask

  task automatic pulse(input logic por, input logic wrst, input logic irq);
    @(negedge clk);
    rd_valid = 0; sfr_we_i = 0;
    por_i = por; wrst_i = wrst; irq_i = irq;
    idle_cyc();
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] d,
                    input logic [3:0] pins, input string tag);
    exp_t e;
    e.data = d; e.pins = pins; e.tag = tag;
    @(negedge clk);
    por_i = 0; wrst_i = 0; sfr_we_i = 0; irq_i = 0;
    sfr_addr_i = a;
    q.push_back(e);
    rd_valid = 1;
    idle_cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_cyc();
    rd(8'h87, 8'h10, 4'b0000, "R1 power-on value");
    wr(8'h87, 8'hCF, 1'b0);
    rd(8'h87, 8'hCF, 4'b1111, "R3 R5 R9 R11 full write");
    wr(8'h86, 8'h00, 1'b0);
    rd(8'h87, 8'hCF, 4'b1111, "R2 write at other address ignored");
    rd(8'h86, 8'h00, 4'b1111, "R2 read at other address is zero");
    pulse(1'b0, 1'b0, 1'b1);
    rd(8'h87, 8'hCE, 4'b1110, "R6 R7 irq clears idle keeps pd");
    wr(8'h87, 8'h01, 1'b1);
    rd(8'h87, 8'h00, 4'b0000, "R8 irq beats idle write");
    wr(8'h87, 8'h13, 1'b0);
    rd(8'h87, 8'h13, 4'b0011, "R5 set cold flag by write");
    pulse(1'b0, 1'b1, 1'b0);
    rd(8'h87, 8'h10, 4'b0000, "R4 R10 R6 R7 warm reset keeps flag 1");
    wr(8'h87, 8'hCE, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    rd(8'h87, 8'h00, 4'b0000, "R4 R10 warm reset keeps flag 0");
    pulse(1'b1, 1'b0, 1'b0);
    rd(8'h87, 8'h10, 4'b0000, "R4 R1 power-on sets flag");
    wr(8'h87, 8'h40, 1'b0);
    rd(8'h87, 8'h40, 4'b0100, "R11 framing select pin");
    wr(8'h87, 8'h88, 1'b0);
    rd(8'h87, 8'h88, 4'b1000, "R9 R11 double baud pin");
    wr(8'h87, 8'h06, 1'b0);
    rd(8'h87, 8'h06, 4'b0010, "R9 R12 registered read");
    repeat (3) idle_cyc();
    done = 1;
  end

  initial begin
    fork
      wait (done == 1'b1);
      begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule